// File: doc/BRIEF.md
# ARX Sponge Permutation Core

This block permutes a sponge state of sixteen words, held as a 4x4 matrix in row-major order: words 0 to 3 form the top row. Each round mixes the four columns with a quarter function and then mixes the four diagonals with the same function. The quarter function uses a carry-free nonlinear "addition" and four right rotations. The word width (32 or 64 bits) and the round count are parameters. The core computes one complete round per clock.

A client loads all sixteen words in parallel with a one-cycle `start` pulse while the core is idle. After the programmed number of rounds, a one-cycle `done` strobe marks the permuted state on `state_out`. That value is held until the next accepted start. A start pulse that arrives while the core is working is dropped. A start in the same cycle as `done` is accepted and begins a new permutation at once.

Top module: `arx_perm_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `state_out` is all zeros.
- R2: A `start` sampled while `busy` is 0 loads `state_in` and makes `busy` 1 in the next cycle, with `done` 0.
- R3: `done` rises exactly ROUNDS clock edges after the loading edge, in the same cycle that `busy` falls. `done` stays low in all earlier cycles.
- R4: `done` is high for exactly one cycle per permutation.
- R5: `state_out` at `done` equals the round function applied ROUNDS times. Word i sits at bits [i*W +: W]. A round applies the quarter function to the columns (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). It then applies it to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14).
- R6: The quarter function on (a,b,c,d) runs, in this order: a=H(a,b), d=rotr(a^d,r0), c=H(c,d), b=rotr(c^b,r1), a=H(a,b), d=rotr(a^d,r2), c=H(c,d), b=rotr(c^b,r3). Here H(x,y)=(x^y)^((x&y)<<1), with the top bit of the shift discarded.
- R7: A `start` pulse while `busy` is 1 has no effect: both the result and its timing are those of the earlier start.
- R8: While the core is idle and no start is sampled, `state_out` does not change, whatever `state_in` does.
- R9: A `start` sampled in the cycle where `done` is 1 is accepted as a new load.
- R10: The same input always yields the same output.
- R11: Rotation amounts (r0,r1,r2,r3) are (8,11,16,31) for W=32 and (8,19,40,63) for W=64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request, one-cycle pulse |
| state_in | input | 16*W | Input state, word i at [i*W +: W] |
| busy | output | 1 | Permutation in progress |
| done | output | 1 | One-cycle strobe: result valid |
| state_out | output | 16*W | Working and result state |

## Verification
The completion strobe and a new load can fall in the same cycle. The bench raises `start` with fresh data in exactly the cycle where `done` is seen high. It judges the outcome by `busy` rising at the next edge, `done` dropping, and the second result matching the model after another full round count. A start during the busy window is also provoked, and it passes only if the first permutation's latency and value are left unchanged.

// File: rtl/arx_perm_core.sv
module arx_perm_core #(
  parameter int W      = 32,
  parameter int ROUNDS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [16*W-1:0] state_in,
  output logic            busy,
  output logic            done,
  output logic [16*W-1:0] state_out
);

  localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam int R0 = 8;
  localparam int R1 = (W == 64) ? 19 : 11;
  localparam int R2 = (W == 64) ? 40 : 16;
  localparam int R3 = (W == 64) ? 63 : 31;

  typedef logic [W-1:0] word_t;

  function automatic word_t hmix(word_t x, word_t y);
    return (x ^ y) ^ ((x & y) << 1);
  endfunction

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (W - n));
  endfunction

  function automatic logic [4*W-1:0] quarter(logic [4*W-1:0] q);
    word_t a, b, c, d;
    {d, c, b, a} = q;
    a = hmix(a, b);
    d = rotr(a ^ d, R0);
    c = hmix(c, d);
    b = rotr(c ^ b, R1);
    a = hmix(a, b);
    d = rotr(a ^ d, R2);
    c = hmix(c, d);
    b = rotr(c ^ b, R3);
    return {d, c, b, a};
  endfunction

  logic [16*W-1:0] st;
  logic [CW-1:0]   cnt;
  word_t cur [16];
  word_t col [16];
  word_t sh  [16];
  word_t dg  [16];
  word_t nxt [16];
  logic [16*W-1:0] nxt_flat;

  assign state_out = st;

  always_comb begin
    for (int i = 0; i < 16; i++) cur[i] = st[i*W +: W];
    for (int c = 0; c < 4; c++)
      {col[12+c], col[8+c], col[4+c], col[c]} = quarter({cur[12+c], cur[8+c], cur[4+c], cur[c]});
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 4; j++)
        sh[r*4+j] = col[r*4 + ((j + r) % 4)];
    for (int c = 0; c < 4; c++)
      {dg[12+c], dg[8+c], dg[4+c], dg[c]} = quarter({sh[12+c], sh[8+c], sh[4+c], sh[c]});
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 4; j++)
        nxt[r*4 + ((j + r) % 4)] = dg[r*4+j];
    for (int i = 0; i < 16; i++) nxt_flat[i*W +: W] = nxt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st   <= state_in;
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else begin
        st <= nxt_flat;
        if (cnt == CW'(ROUNDS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(state_out));

endmodule

// File: tb/arx_perm_core_bench.sv
module arx_perm_core_bench;
  localparam int L32 = 4;
  localparam int L64 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s32 = 1'b0, s64 = 1'b0;
  logic [511:0]  in32 = '0;
  logic [1023:0] in64 = '0;
  logic b32, d32, b64, d64;
  logic [511:0]  o32;
  logic [1023:0] o64;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  arx_perm_core #(.W(32), .ROUNDS(L32)) u_arx_perm_core (
    .clk(clk), .rst_n(rst_n), .start(s32), .state_in(in32),
    .busy(b32), .done(d32), .state_out(o32));

  arx_perm_core #(.W(64), .ROUNDS(L64)) u_arx_perm_core_w64 (
    .clk(clk), .rst_n(rst_n), .start(s64), .state_in(in64),
    .busy(b64), .done(d64), .state_out(o64));

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, input logic [1023:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_h(logic [63:0] x, logic [63:0] y, logic [63:0] m);
    return ((x ^ y) ^ ((x & y) << 1)) & m;
  endfunction

  function automatic logic [63:0] m_r(logic [63:0] x, int n, int w, logic [63:0] m);
    logic [63:0] v = x & m;
    return ((v >> n) | (v << (w - n))) & m;
  endfunction

  function automatic logic [1023:0] model(logic [1023:0] s, int w, int l);
    logic [63:0] v [16];
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    int grp [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                       '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    int rt [4];
    logic [63:0] a, b, c, d;
    logic [1023:0] o = '0;
    if (w == 64) rt = '{8, 19, 40, 63}; else rt = '{8, 11, 16, 31};
    for (int i = 0; i < 16; i++) v[i] = (w == 64) ? s[i*64 +: 64] : {32'h0, s[i*32 +: 32]};
    for (int r = 0; r < l; r++)
      for (int g = 0; g < 8; g++) begin
        a = v[grp[g][0]]; b = v[grp[g][1]]; c = v[grp[g][2]]; d = v[grp[g][3]];
        a = m_h(a, b, m); d = m_r(a ^ d, rt[0], w, m);
        c = m_h(c, d, m); b = m_r(c ^ b, rt[1], w, m);
        a = m_h(a, b, m); d = m_r(a ^ d, rt[2], w, m);
        c = m_h(c, d, m); b = m_r(c ^ b, rt[3], w, m);
        v[grp[g][0]] = a; v[grp[g][1]] = b; v[grp[g][2]] = c; v[grp[g][3]] = d;
      end
    for (int i = 0; i < 16; i++)
      if (w == 64) o[i*64 +: 64] = v[i]; else o[i*32 +: 32] = v[i][31:0];
    return o;
  endfunction

  function automatic logic [1023:0] pat(int kind, int w);
    logic [1023:0] o = '0;
    logic [63:0] x;
    for (int i = 0; i < 16; i++) begin
      case (kind)
        0: x = 64'(i);
        1: x = '1;
        2: x = 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15 ^ 64'hC3A5_5A3C_0F0F_F0F0;
        default: x = '0;
      endcase
      if (w == 64) o[i*64 +: 64] = x; else o[i*32 +: 32] = x[31:0];
    end
    return o;
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run32(input logic [511:0] din, output logic [511:0] dout);
    in32 = din; s32 = 1'b1;
    cyc();
    s32 = 1'b0;
    chk(b32 && !d32, "R2 busy after load", 1024'({b32, d32}), 1024'(2'b10));
    for (int k = 1; k <= L32; k++) begin
      cyc();
      if (k < L32) chk(!d32, "R3 early done", 1024'(d32), 1024'(0));
      else chk(d32 && !b32, "R3 done at round count", 1024'({b32, d32}), 1024'(2'b01));
    end
    dout = o32;
  endtask

  task automatic t_reset();
    chk(!b32 && !d32, "R1 reset flags", 1024'({b32, d32}), 1024'(0));
    chk(o32 == '0, "R1 reset state", 1024'(o32), 1024'(0));
  endtask

  task automatic t_pattern(input int kind);
    logic [511:0] r;
    logic [511:0] e;
    e = model(1024'(pat(kind, 32)), 32, L32)[511:0];
    run32(pat(kind, 32)[511:0], r);
    chk(r == e, "R5 R6 R11 result w32", 1024'(r), 1024'(e));
    cyc();
    chk(!d32, "R4 done one cycle", 1024'(d32), 1024'(0));
  endtask

  task automatic t_ignore();
    logic [511:0] first = pat(2, 32)[511:0];
    logic [511:0] e = model(1024'(first), 32, L32)[511:0];
    in32 = first; s32 = 1'b1;
    cyc();
    s32 = 1'b0;
    cyc();
    in32 = ~first; s32 = 1'b1;
    cyc();
    s32 = 1'b0;
    for (int k = 3; k <= L32; k++) begin
      cyc();
      if (k < L32) chk(!d32, "R7 timing kept", 1024'(d32), 1024'(0));
    end
    chk(d32, "R7 done timing kept", 1024'(d32), 1024'(1));
    chk(o32 == e, "R7 result of first start", 1024'(o32), 1024'(e));
    for (int k = 0; k < 5; k++) begin
      in32 = pat(k % 3, 32)[511:0];
      cyc();
      chk(o32 == e && !b32, "R8 output held", 1024'(o32), 1024'(e));
    end
  endtask

  task automatic t_back2back();
    logic [511:0] r;
    logic [511:0] e1 = model(pat(0, 32), 32, L32)[511:0];
    logic [511:0] e2 = model(pat(1, 32), 32, L32)[511:0];
    run32(pat(0, 32)[511:0], r);
    chk(r == e1, "R9 first result", 1024'(r), 1024'(e1));
    in32 = pat(1, 32)[511:0]; s32 = 1'b1;
    cyc();
    s32 = 1'b0;
    chk(b32 && !d32, "R9 start at done accepted", 1024'({b32, d32}), 1024'(2'b10));
    for (int k = 1; k <= L32; k++) cyc();
    chk(d32 && o32 == e2, "R9 second result", 1024'(o32), 1024'(e2));
    cyc();
  endtask

  task automatic t_repeat();
    logic [511:0] r1, r2;
    run32(pat(2, 32)[511:0] ^ 512'h5A, r1);
    cyc();
    run32(pat(2, 32)[511:0] ^ 512'h5A, r2);
    chk(r1 == r2, "R10 repeatable", 1024'(r2), 1024'(r1));
    cyc();
  endtask

  task automatic t_wide(input int kind);
    logic [1023:0] e = model(pat(kind, 64), 64, L64);
    in64 = pat(kind, 64); s64 = 1'b1;
    cyc();
    s64 = 1'b0;
    for (int k = 1; k <= L64; k++) cyc();
    chk(d64, "R3 done w64", 1024'(d64), 1024'(1));
    chk(o64 == e, "R11 result w64", o64, e);
    cyc();
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_pattern(0);
    t_pattern(1);
    t_pattern(2);
    t_pattern(3);
    t_ignore();
    t_back2back();
    t_repeat();
    t_wide(2);
    t_wide(1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule